// File: doc/BRIEF.md
# Microwire Serial EEPROM Master

This block is a host-side master for a three-wire-plus-select serial EEPROM that holds 16-bit words. It drives chip select, the serial clock and the serial data line toward the memory, and samples the memory's data output. One request carries a direction (read or write), a start address and a word count. The block splits the request into one bus command per word, walking the address upward from the start value.

Reads return each word with a one-cycle valid strobe. A write burst is opened with a program-enable command and closed with a program-disable command. After each written word the block polls the memory until the word is committed. If the memory never reports ready within a set number of serial clocks, the block flags an error, skips the remaining words and still closes the burst. The serial clock high and low times come from divider parameters. The address width is a parameter that takes the value 6 or 8.

Top module: `mw_eeprom_master`

## Requirements
- R1: After reset, cs, sk, di, done, err and rd_valid are 0 and req_ready is 1.
- R2: Each sk high phase lasts exactly SK_HI clock cycles, and each sk low phase lasts at least SK_LO clock cycles.
- R3: di changes only while sk is low. so is sampled at the clock edge where sk rises.
- R4: A read command first holds cs high for one sk period with di low. It then shifts out 1, 1, 0 and the AW address bits MSB first. It samples 17 bits on so and discards the first (dummy) bit. The remaining 16 bits, MSB first, are presented on rd_data with a one-cycle rd_valid pulse.
- R5: A write command shifts out 1, 0, 1, the address MSB first and the 16 wr_data bits MSB first. wr_data is captured as the command is formed, and wr_take then pulses for one cycle so the source can present the next word.
- R6: A write burst is preceded by an enable command and followed by a disable command. The enable command is 1, 0, 0, 1, 1 followed by zeros. The disable command is 1 followed by zeros. Each is AW+3 bits long, so each select window carries AW+4 sk pulses.
- R7: After the last data bit of a write, cs goes low for exactly one sk period. cs then rises, and sk keeps pulsing until so is sampled as 1. Only after that is the device deselected.
- R8: Each word is a separate command at address start, start+1, ..., start+count-1. Between any two commands, cs stays low while exactly one sk pulse is issued.
- R9: req_ready is high only when the block is idle. A request is accepted when req_valid and req_ready are both high. done pulses for one cycle when the request completes.
- R10: If so is not sampled as 1 within POLL_MAX poll periods, err is set and held until the next request is accepted. The remaining words are skipped, the disable command is still sent, and done then pulses.
- R11: A request with a count of zero completes with done on the accepting edge and produces no cs activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | First word address |
| req_count | input | AW+1 | Number of words |
| wr_data | input | 16 | Word to write next |
| wr_take | output | 1 | Pulse after wr_data has been captured |
| rd_data | output | 16 | Last word read |
| rd_valid | output | 1 | rd_data holds a new word |
| done | output | 1 | Request completed |
| err | output | 1 | Write completion poll timed out |
| cs | output | 1 | Chip select to memory |
| sk | output | 1 | Serial clock to memory |
| di | output | 1 | Serial data to memory |
| so | input | 1 | Serial data from memory |

## Verification
The bench attaches a behavioural memory model to the serial pins and walks a table of read and write bursts, some of them at the top of the address range.

Each class of error shows up in a specific way:
- A controller that kept the leading dummy bit would return every word shifted right by one.
- A controller that sampled on the wrong edge would also return wrong read data.
- A wrong frame pad would show up as a wrong enable or disable length.
- A missing deselect pulse would leave the model mid-command.
- A poll that ended one period early or late would show as a wrong poll count.

Directed cases cover a count of zero and a memory that never signals ready. The timeout case must raise err, write only the first word, and still leave the memory write-protected.

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master #(
  parameter int AW       = 6,
  parameter int SK_HI    = 75,
  parameter int SK_LO    = 25,
  parameter int POLL_MAX = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [AW:0]   req_count,
  input  logic [15:0]   wr_data,
  output logic          wr_take,
  output logic [15:0]   rd_data,
  output logic          rd_valid,
  output logic          done,
  output logic          err,
  output logic          cs,
  output logic          sk,
  output logic          di,
  input  logic          so
);
  localparam int FW = AW + 19;
  localparam int BW = $clog2(FW + 1);
  localparam int TW = $clog2((SK_HI > SK_LO ? SK_HI : SK_LO) + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [FW-1:0] EN_FRAME  = {5'b10011, {(AW-2){1'b0}}, 16'h0000};
  localparam logic [FW-1:0] DIS_FRAME = {1'b1, {(FW-1){1'b0}}};

  typedef enum logic [2:0] {P_IDLE, P_SEL, P_SHIFT, P_READ, P_WLOW, P_POLL, P_DESEL} phase_t;
  typedef enum logic [1:0] {S_EN, S_WORD, S_DIS} stage_t;

  phase_t        ph;
  stage_t        stg;
  logic          is_wr, rdy, abort;
  logic [AW-1:0] addr;
  logic [AW:0]   left;
  logic [FW-1:0] sh;
  logic [BW-1:0] bcnt;
  logic [15:0]   rsh;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;

  wire rise     = (ph != P_IDLE) && !sk && (tcnt == TW'(SK_LO - 1));
  wire slot_end = (ph != P_IDLE) && sk && (tcnt == TW'(SK_HI - 1));

  wire                wr_sel = (ph == P_IDLE) ? req_write : is_wr;
  wire [AW-1:0]       a_sel  = (ph == P_IDLE) ? req_addr : addr;
  wire [FW-1:0]       wframe = wr_sel ? {3'b101, a_sel, wr_data} : {3'b110, a_sel, 16'h0000};
  wire [BW-1:0]       wbits  = wr_sel ? BW'(FW) : BW'(AW + 3);

  assign req_ready = (ph == P_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk <= 1'b0;
      tcnt <= '0;
    end else if (ph == P_IDLE) begin
      sk <= 1'b0;
      tcnt <= '0;
    end else if (rise) begin
      sk <= 1'b1;
      tcnt <= '0;
    end else if (slot_end) begin
      sk <= 1'b0;
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; stg <= S_EN; is_wr <= 1'b0; rdy <= 1'b0; abort <= 1'b0;
      addr <= '0; left <= '0; sh <= '0; bcnt <= '0; rsh <= '0; pcnt <= '0;
      cs <= 1'b0; di <= 1'b0; done <= 1'b0; err <= 1'b0;
      rd_data <= '0; rd_valid <= 1'b0; wr_take <= 1'b0;
    end else begin
      done <= 1'b0;
      rd_valid <= 1'b0;
      wr_take <= 1'b0;
      case (ph)
        P_IDLE: if (req_valid) begin
          is_wr <= req_write;
          err <= 1'b0;
          abort <= 1'b0;
          if (req_count == '0) begin
            done <= 1'b1;
          end else begin
            left <= req_count;
            cs <= 1'b1;
            di <= 1'b0;
            ph <= P_SEL;
            if (req_write) begin
              stg <= S_EN; sh <= EN_FRAME; bcnt <= BW'(AW + 3); addr <= req_addr;
            end else begin
              stg <= S_WORD; sh <= wframe; bcnt <= wbits; addr <= req_addr + 1'b1;
            end
          end
        end
        P_SEL: if (slot_end) begin
          ph <= P_SHIFT;
          di <= sh[FW-1];
          sh <= sh << 1;
        end
        P_SHIFT: if (slot_end) begin
          if (bcnt == BW'(1)) begin
            di <= 1'b0;
            if (stg != S_WORD) begin
              ph <= P_DESEL; cs <= 1'b0;
            end else if (is_wr) begin
              ph <= P_WLOW; cs <= 1'b0;
            end else begin
              ph <= P_READ; bcnt <= BW'(17);
            end
          end else begin
            di <= sh[FW-1];
            sh <= sh << 1;
            bcnt <= bcnt - 1'b1;
          end
        end
        P_READ: begin
          if (rise) rsh <= {rsh[14:0], so};
          if (slot_end) begin
            if (bcnt == BW'(1)) begin
              rd_data <= rsh; rd_valid <= 1'b1; ph <= P_DESEL; cs <= 1'b0;
            end else begin
              bcnt <= bcnt - 1'b1;
            end
          end
        end
        P_WLOW: if (slot_end) begin
          ph <= P_POLL; cs <= 1'b1; pcnt <= '0; rdy <= 1'b0;
        end
        P_POLL: begin
          if (rise) rdy <= so;
          if (slot_end) begin
            if (rdy) begin
              ph <= P_DESEL; cs <= 1'b0;
            end else if (pcnt == PW'(POLL_MAX - 1)) begin
              err <= 1'b1; abort <= 1'b1; ph <= P_DESEL; cs <= 1'b0;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        P_DESEL: if (slot_end) begin
          if (stg == S_DIS || (stg == S_WORD && !is_wr && (abort || left == (AW+1)'(1)))) begin
            done <= 1'b1;
            ph <= P_IDLE;
          end else if (stg == S_WORD && (abort || left == (AW+1)'(1))) begin
            stg <= S_DIS; sh <= DIS_FRAME; bcnt <= BW'(AW + 3); cs <= 1'b1; ph <= P_SEL;
          end else begin
            if (stg == S_WORD) left <= left - 1'b1;
            stg <= S_WORD;
            sh <= wframe;
            bcnt <= wbits;
            addr <= a_sel + 1'b1;
            cs <= 1'b1;
            ph <= P_SEL;
            wr_take <= is_wr;
          end
        end
        default: ph <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_master_chk.sv
module mw_eeprom_master_chk #(
  parameter int SK_HI = 75
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sk,
  input logic di,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic rd_valid
);
  int hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= 0;
    else hi_run <= sk ? hi_run + 1 : 0;
  end

  p_sk_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> hi_run < SK_HI);

  p_di_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> $stable(di));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cs && !sk));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !done) |=> (!req_ready || done));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind mw_eeprom_master mw_eeprom_master_chk #(.SK_HI(SK_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
  .req_valid(req_valid), .req_ready(req_ready), .done(done), .rd_valid(rd_valid)
);

// File: tb/tb_mw_eeprom_master.sv
module tb_mw_eeprom_master;
  localparam int AW = 6;
  localparam int SK_HI = 3;
  localparam int SK_LO = 2;
  localparam int POLL_MAX = 20;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {write, addr, count, seed}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'd5,  8'd3, 8'h11},
    {1'b0, 8'd4,  8'd5, 8'h00},
    {1'b1, 8'd63, 8'd1, 8'h22},
    {1'b0, 8'd62, 8'd2, 8'h00},
    {1'b1, 8'd0,  8'd2, 8'h33},
    {1'b0, 8'd0,  8'd3, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [AW:0] req_count = '0;
  logic [15:0] wr_data;
  logic req_ready, wr_take, rd_valid, done, err, cs, sk, di;
  logic [15:0] rd_data;
  logic mdo = 0;

  int total = 0, bad = 0;
  int cur_addr = 0, widx = 0, rcount = 0;
  logic [7:0] seed_q = 0;
  bit saw_done, err_seen;
  logic [15:0] shadow [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] wf(input int a, input logic [7:0] s);
    return 16'(a * 16'h1357) ^ {s, 8'h5A};
  endfunction

  assign wr_data = wf(cur_addr + widx, seed_q);

  mw_eeprom_master #(.AW(AW), .SK_HI(SK_HI), .SK_LO(SK_LO), .POLL_MAX(POLL_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_count(req_count),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .err(err), .cs(cs), .sk(sk), .di(di), .so(mdo));

  // behavioural memory on the serial pins
  logic [15:0] mem [64];
  logic [15:0] msr, mdata;
  logic [AW-1:0] ma;
  int mst = 0, mnb = 0, mkind = 0, frame_bits = 0;
  int busy = 0, busy_len = 3, polls = 0, last_polls = -1;
  int lowcnt = 0, lowbad = 0, csrise = 0, ewen_len = 0, ewds_len = 0;
  bit wen = 0, pend = 0, stat = 0, first = 1;

  always @(negedge cs) begin
    if (stat) last_polls = polls;
    if (mkind == 1) ewen_len = frame_bits;
    if (mkind == 2) ewds_len = frame_bits;
    if (pend) begin stat = 1; busy = busy_len; pend = 0; polls = 0; end
    else stat = 0;
    mst = 0; lowcnt = 0; mdo = 0;
  end

  always @(posedge cs) begin
    csrise++;
    if (!first && lowcnt != 1) lowbad++;
    first = 0; frame_bits = 0; mkind = 0;
    if (stat) mdo = (busy == 0);
  end

  always @(posedge sk) begin
    if (!cs) lowcnt++;
    else begin
      frame_bits++;
      if (stat) begin
        polls++;
        if (busy > 0) busy--;
        mdo = (busy == 0);
      end else begin
        case (mst)
          0: if (di) begin mst = 1; mnb = 0; msr = 0; end
          1: begin
            msr = {msr[14:0], di}; mnb++;
            if (mnb == 2 + AW) begin
              ma = msr[AW-1:0];
              case (msr[AW+1:AW])
                2'b10: begin mst = 2; mdata = mem[ma]; mdo = 0; end
                2'b01: begin mst = 3; mnb = 0; end
                2'b00: begin
                  if (msr[AW-1:AW-2] == 2'b11) begin wen = 1; mkind = 1; end
                  else if (msr[AW-1:AW-2] == 2'b00) begin wen = 0; mkind = 2; end
                  mst = 5;
                end
                default: mst = 5;
              endcase
            end
          end
          2: begin mdo = mdata[15]; mdata = {mdata[14:0], 1'b0}; end
          3: begin
            msr = {msr[14:0], di}; mnb++;
            if (mnb == 16) begin
              if (wen) begin mem[ma] = msr; pend = 1; end
              mst = 5;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // pin timing monitors
  int hi_run = 0, lo_run = 0, sk_bad = 0, di_bad = 0;
  logic psk = 0, pdi = 0;
  always @(negedge clk) begin
    if (sk && psk && di != pdi) di_bad++;
    if (sk) begin
      if (!psk && lo_run < SK_LO) sk_bad++;
      hi_run++; lo_run = 0;
    end else begin
      if (psk && hi_run != SK_HI) sk_bad++;
      lo_run++; hi_run = 0;
    end
    psk = sk; pdi = di;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input int a, input int n, input logic [7:0] s);
    req_write = wr; req_addr = AW'(a); req_count = (AW+1)'(n);
    cur_addr = a; seed_q = s; widx = 0; rcount = 0; saw_done = 0; err_seen = 0;
    req_valid = 1;
    for (int cyc = 0; cyc < 20000 && !saw_done; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        req_valid = 0;
        if (n != 0) chk(req_ready == 0, "R9 busy", req_ready, 0);
      end
      if (rd_valid) begin
        chk(rd_data == shadow[(a + rcount) % 64], "R4/R8 read word", rd_data, shadow[(a + rcount) % 64]);
        rcount++;
      end
      if (wr_take) widx++;
      if (done) begin saw_done = 1; err_seen = err; end
    end
    chk(saw_done, "R9 done", saw_done, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'hC000 | 16'(i * 37);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cs, sk, di, done, err, rd_valid} == 6'b0, "R1 outputs", {cs, sk, di, done, err, rd_valid}, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      automatic bit wr = VEC[v][24];
      automatic int a = int'(VEC[v][23:16]);
      automatic int n = int'(VEC[v][15:8]);
      automatic logic [7:0] s = VEC[v][7:0];
      ewen_len = 0; ewds_len = 0; last_polls = -1;
      run_op(wr, a, n, s);
      chk(err_seen == 0, "R10 no error", err_seen, 0);
      if (wr) begin
        for (int k = 0; k < n; k++) shadow[(a + k) % 64] = wf(a + k, s);
        chk(widx == n, "R5 words taken", widx, n);
        chk(ewen_len == AW + 4, "R6 enable length", ewen_len, AW + 4);
        chk(ewds_len == AW + 4, "R6 disable length", ewds_len, AW + 4);
        chk(wen == 0, "R6 protected after burst", wen, 0);
        chk(last_polls == busy_len + 1, "R7 poll periods", last_polls, busy_len + 1);
      end else begin
        chk(rcount == n, "R8 word count", rcount, n);
      end
      repeat (3) @(negedge clk);
    end

    // R11 zero count
    begin
      automatic int cr = csrise;
      run_op(1'b0, 10, 0, 8'h00);
      chk(csrise == cr, "R11 no cs activity", csrise, cr);
      chk(rcount == 0, "R11 no words", rcount, 0);
    end

    // R10 timeout: memory never ready
    busy_len = 1000;
    ewds_len = 0;
    run_op(1'b1, 20, 2, 8'h44);
    chk(err_seen == 1, "R10 err at done", err_seen, 1);
    chk(widx == 1, "R10 remaining words skipped", widx, 1);
    chk(last_polls == POLL_MAX, "R10 poll limit", last_polls, POLL_MAX);
    chk(ewds_len == AW + 4, "R10 disable still sent", ewds_len, AW + 4);
    chk(wen == 0, "R10 protected", wen, 0);
    shadow[20] = wf(20, 8'h44);
    busy_len = 3;
    @(negedge clk);
    chk(err == 1, "R10 err held", err, 1);
    run_op(1'b0, 20, 2, 8'h00);
    chk(err_seen == 0, "R10 err cleared", err_seen, 0);
    chk(rcount == 2, "R10 readback count", rcount, 2);

    chk(sk_bad == 0, "R2 sk phase lengths", sk_bad, 0);
    chk(di_bad == 0, "R3 di steady while sk high", di_bad, 0);
    chk(lowbad == 0, "R7/R8 single deselect pulse", lowbad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule